// File: doc/BRIEF.md
# SIMT Warp Lane Sequencer

This block accepts one instruction meant for a full 32-thread warp and plays it out over a lane array that is narrower than the warp. The array is split into one or more lane groups. Each group works through the warp in consecutive sub-cycles and handles one slice of threads in each sub-cycle. In every cycle, every enabled lane runs the same opcode.

The block has two build-time configurations. In the first, a single 8-lane group needs four sub-cycles per warp instruction. In the second, two 16-lane groups each take two sub-cycles per warp instruction, and each group can carry a different warp, so their windows overlap. Integer and single-precision work uses the groups independently in this way. A double-precision instruction in the dual configuration claims both groups together. They then behave as one 16-lane unit for that warp: the group 0 lanes carry the threads, and group 1 is held.

For each group, the block reports the lane enables, the thread index of every lane, the warp id, the opcode, a busy flag and a done pulse. It does no arithmetic.

Top module: `simt_lane_seq`

## Requirements
- R1: Once an issue is accepted, the receiving group is busy for exactly WARP/GROUP_LANES consecutive cycles, starting the cycle after acceptance. That is 4 cycles for an 8-lane group and 2 cycles for a 16-lane group.
- R2: In sub-cycle k, lane L of a group reports thread index k*GROUP_LANES+L. The field for global lane n sits at lane_tid bits [n*5 +: 5].
- R3: A lane enable is high only while its group is busy and the active-mask bit of that lane's thread is set. A warp whose mask is all zero still occupies its full sub-cycle count and still pulses done, but raises no enable.
- R4: grp_done of a group pulses only in that group's final sub-cycle, and the group is idle in the next cycle. In the single-group configuration, issue_ready stays low from the cycle after acceptance through the final sub-cycle and is high again in the cycle after done.
- R5: For every sub-cycle of an instruction, a busy group presents the warp id and opcode captured at acceptance.
- R6: In the dual configuration, a non-double-precision issue goes to the lowest-numbered idle group. issue_ready stays high while at least one group is idle, so two warps can run overlapped.
- R7: In the dual configuration, a double-precision issue is not accepted (issue_ready low) while either group is busy, and it is accepted once both groups are idle.
- R8: A merged double-precision instruction drives its threads on the group 0 lanes over 2 sub-cycles. During that time both groups read busy, group 1 lanes stay disabled, dp_merged is high, and both done bits pulse in the final sub-cycle.
- R9: In the single-group configuration, issue_dp changes neither the timing nor the lane enables, and dp_merged stays low.
- R10: While reset is asserted, and after it is released, all groups are idle, no lane is enabled, no done is raised, dp_merged is low and issue_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The offered instruction can be taken this cycle |
| issue_warp | input | WID_W | Warp id of the offered instruction |
| issue_mask | input | WARP | Per-thread active mask, bit t for thread t |
| issue_op | input | OP_W | Opcode |
| issue_dp | input | 1 | Double-precision flag |
| lane_en | output | GROUPS*GROUP_LANES | Lane enables, group g at bits [g*GROUP_LANES +: GROUP_LANES] |
| lane_tid | output | GROUPS*GROUP_LANES*5 | Thread index per lane, 5 bits each |
| grp_busy | output | GROUPS | Group is executing an instruction |
| grp_done | output | GROUPS | Group is in its final sub-cycle |
| grp_warp | output | GROUPS*WID_W | Warp id held by each group |
| grp_op | output | GROUPS*OP_W | Opcode held by each group |
| dp_merged | output | 1 | Both groups are serving one double-precision warp |

## Verification
A corrupted sub-cycle counter shows up on lane_tid and on the mask slice behind lane_en in the very next cycle. A counter that stalls or runs past its last value also moves grp_done and the return of issue_ready off the expected cycle. Faults in group selection or the merge flag are visible at once: the wrong bit of grp_busy rises, or group 1 lanes are enabled during a double-precision warp, in the first cycle after acceptance. A lost mask or lost opcode appears on the first sub-cycle that reads it.

// File: rtl/simt_lane_seq.sv
module simt_lane_seq #(
  parameter int WARP        = 32,
  parameter int GROUP_LANES = 16,
  parameter int GROUPS      = 2,
  parameter int WID_W       = 6,
  parameter int OP_W        = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  issue_valid,
  output logic                                  issue_ready,
  input  logic [WID_W-1:0]                      issue_warp,
  input  logic [WARP-1:0]                       issue_mask,
  input  logic [OP_W-1:0]                       issue_op,
  input  logic                                  issue_dp,
  output logic [GROUPS*GROUP_LANES-1:0]         lane_en,
  output logic [GROUPS*GROUP_LANES*$clog2(WARP)-1:0] lane_tid,
  output logic [GROUPS-1:0]                     grp_busy,
  output logic [GROUPS-1:0]                     grp_done,
  output logic [GROUPS*WID_W-1:0]               grp_warp,
  output logic [GROUPS*OP_W-1:0]                grp_op,
  output logic                                  dp_merged
);
  localparam int STEPS = WARP / GROUP_LANES;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int LW    = $clog2(GROUP_LANES);
  localparam int TW    = $clog2(WARP);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic             busy_r [GROUPS];
  logic [SW-1:0]    step_r [GROUPS];
  logic [WARP-1:0]  mask_r [GROUPS];
  logic [WID_W-1:0] warp_r [GROUPS];
  logic [OP_W-1:0]  op_r   [GROUPS];
  logic             merged_r;
  logic [GROUPS-1:0] pick;
  logic             dual_dp, accept;

  assign dual_dp     = (GROUPS > 1) && issue_dp;
  assign issue_ready = dual_dp ? ~|grp_busy : ~&grp_busy;
  assign accept      = issue_valid && issue_ready;
  assign dp_merged   = merged_r;

  always_comb begin
    pick = '0;
    if (dual_dp) pick = '1;
    else
      for (int g = GROUPS - 1; g >= 0; g--)
        if (!grp_busy[g]) begin
          pick    = '0;
          pick[g] = 1'b1;
        end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            merged_r <= 1'b0;
    else if (accept && dual_dp)            merged_r <= 1'b1;
    else if (busy_r[0] && step_r[0] == LAST) merged_r <= 1'b0;

  for (genvar g = 0; g < GROUPS; g++) begin : grp
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        busy_r[g] <= 1'b0;
        step_r[g] <= '0;
        mask_r[g] <= '0;
        warp_r[g] <= '0;
        op_r[g]   <= '0;
      end else if (accept && pick[g]) begin
        busy_r[g] <= 1'b1;
        step_r[g] <= '0;
        mask_r[g] <= (dual_dp && g != 0) ? '0 : issue_mask;
        warp_r[g] <= issue_warp;
        op_r[g]   <= issue_op;
      end else if (busy_r[g]) begin
        if (step_r[g] == LAST) busy_r[g] <= 1'b0;
        else                   step_r[g] <= step_r[g] + 1'b1;
      end

    assign grp_busy[g]                  = busy_r[g];
    assign grp_done[g]                  = busy_r[g] && step_r[g] == LAST;
    assign grp_warp[g*WID_W +: WID_W]   = warp_r[g];
    assign grp_op[g*OP_W +: OP_W]       = op_r[g];

    for (genvar l = 0; l < GROUP_LANES; l++) begin : lane
      logic [TW-1:0] tid;
      assign tid = TW'({step_r[g], LW'(l)});
      assign lane_tid[(g*GROUP_LANES+l)*TW +: TW] = tid;
      assign lane_en[g*GROUP_LANES+l] = busy_r[g] & mask_r[g][tid];
    end
  end
endmodule

// File: rtl/simt_lane_seq_chk.sv
module simt_lane_seq_chk #(
  parameter int GROUPS      = 2,
  parameter int GROUP_LANES = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          issue_valid,
  input logic                          issue_ready,
  input logic                          issue_dp,
  input logic [GROUPS-1:0]             grp_busy,
  input logic [GROUPS-1:0]             grp_done,
  input logic [GROUPS*GROUP_LANES-1:0] lane_en,
  input logic                          dp_merged
);
  // R1
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> (grp_busy != '0));

  for (genvar g = 0; g < GROUPS; g++) begin : per_grp
    // R4
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done[g] |=> !grp_busy[g]);
    // R1
    busy_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_busy[g] && !grp_done[g]) |=> grp_busy[g]);
    // R3
    lanes_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[g*GROUP_LANES +: GROUP_LANES] != '0) |-> grp_busy[g]);
  end

  if (GROUPS == 1) begin : single
    // R4
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_busy[0] |-> !issue_ready);
    // R9
    never_merged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dp_merged);
  end else begin : dual
    // R7
    dp_claims_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && issue_dp) |=> (&grp_busy && dp_merged));
    // R8
    merged_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_merged |-> (lane_en[GROUP_LANES +: GROUP_LANES] == '0 && &grp_busy));
  end
endmodule

bind simt_lane_seq simt_lane_seq_chk #(.GROUPS(GROUPS), .GROUP_LANES(GROUP_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_dp(issue_dp), .grp_busy(grp_busy), .grp_done(grp_done),
  .lane_en(lane_en), .dp_merged(dp_merged));

// File: tb/sim_simt_lane_seq.sv
module sim_simt_lane_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic d_valid = 0, d_ready, d_dp = 0, d_merged;
  logic [5:0] d_warp = '0;
  logic [31:0] d_mask = '0, d_en;
  logic [7:0] d_op = '0;
  logic [159:0] d_tid;
  logic [1:0] d_busy, d_done;
  logic [11:0] d_gwarp;
  logic [15:0] d_gop;

  logic s_valid = 0, s_ready, s_dp = 0, s_merged;
  logic [5:0] s_warp = '0, s_gwarp;
  logic [31:0] s_mask = '0;
  logic [7:0] s_op = '0, s_en, s_gop;
  logic [39:0] s_tid;
  logic [0:0] s_busy, s_done;

  simt_lane_seq u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(d_valid), .issue_ready(d_ready),
    .issue_warp(d_warp), .issue_mask(d_mask), .issue_op(d_op), .issue_dp(d_dp),
    .lane_en(d_en), .lane_tid(d_tid), .grp_busy(d_busy), .grp_done(d_done),
    .grp_warp(d_gwarp), .grp_op(d_gop), .dp_merged(d_merged));

  simt_lane_seq #(.GROUP_LANES(8), .GROUPS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .issue_valid(s_valid), .issue_ready(s_ready),
    .issue_warp(s_warp), .issue_mask(s_mask), .issue_op(s_op), .issue_dp(s_dp),
    .lane_en(s_en), .lane_tid(s_tid), .grp_busy(s_busy), .grp_done(s_done),
    .grp_warp(s_gwarp), .grp_op(s_gop), .dp_merged(s_merged));

  // {dp, warp, op, mask}
  localparam logic [46:0] VEC [6] = '{
    {1'b0, 6'd1,  8'h10, 32'hFFFF_FFFF},
    {1'b0, 6'd2,  8'h21, 32'h0000_0000},
    {1'b0, 6'd3,  8'h32, 32'hA5A5_5A5A},
    {1'b1, 6'd4,  8'h43, 32'h8000_0001},
    {1'b0, 6'd63, 8'hFE, 32'h1234_5678},
    {1'b1, 6'd5,  8'h54, 32'h00FF_0F00}};

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic run_single(logic [46:0] v);
    logic [31:0] m = v[31:0];
    @(negedge clk);
    check("R4", "single ready before issue", s_ready, 1);
    s_valid = 1; s_dp = v[46]; s_warp = v[45:40]; s_op = v[39:32]; s_mask = m;
    @(negedge clk);
    s_valid = 0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      check("R3", "single lane_en", s_en, m[k*8 +: 8]);
      for (int l = 0; l < 8; l++) check("R2", "single tid", s_tid[l*5 +: 5], k*8 + l);
      check("R5", "single op", s_gop, v[39:32]);
      check("R5", "single warp", s_gwarp, v[45:40]);
      check("R4", "single done", s_done, k == 3);
      check("R4", "single ready while busy", s_ready, 0);
      check("R1", "single busy", s_busy, 1);
      check("R9", "single merged", s_merged, 0);
    end
    @(negedge clk);
    check("R1", "single idle after 4", s_busy, 0);
    check("R4", "single ready after done", s_ready, 1);
    check("R3", "single lanes off", s_en, 0);
  endtask

  initial begin
    logic [31:0] ma = 32'hDEAD_BEEF, mb = 32'h0F0F_3C3C, mc = 32'h1357_9BDF, md = 32'hC001_7E55;
    repeat (2) @(negedge clk);
    // R10 during reset
    check("R10", "dual busy in reset", d_busy, 0);
    check("R10", "dual lanes in reset", d_en, 0);
    check("R10", "dual ready in reset", d_ready, 1);
    check("R10", "single lanes in reset", s_en, 0);
    rst_n = 1;
    @(negedge clk);
    check("R10", "dual done after reset", d_done, 0);
    check("R10", "dual merged after reset", d_merged, 0);
    check("R10", "single busy after reset", s_busy, 0);

    foreach (VEC[i]) run_single(VEC[i]);

    // R6 overlapped warps in the dual configuration
    @(negedge clk);
    d_valid = 1; d_dp = 0; d_warp = 1; d_mask = ma; d_op = 8'h11;
    @(negedge clk);
    check("R1", "dual g0 starts", d_busy, 2'b01);
    check("R3", "dual g0 step0 lanes", d_en, {16'h0, ma[15:0]});
    check("R6", "ready with g1 idle", d_ready, 1);
    d_warp = 2; d_mask = mb; d_op = 8'h22;
    @(negedge clk);
    d_valid = 0;
    check("R6", "both busy", d_busy, 2'b11);
    check("R4", "g0 done", d_done, 2'b01);
    check("R3", "dual overlapped lanes", d_en, {mb[15:0], ma[31:16]});
    check("R2", "g0 step1 lane3 tid", d_tid[3*5 +: 5], 19);
    check("R2", "g1 step0 lane3 tid", d_tid[19*5 +: 5], 3);
    check("R5", "g1 warp", d_gwarp[11:6], 2);
    check("R5", "g1 op", d_gop[15:8], 8'h22);
    check("R6", "ready low when full", d_ready, 0);
    d_valid = 1; d_warp = 3; d_mask = mc; d_op = 8'h33;
    @(negedge clk);
    check("R4", "g0 idle after done", d_busy, 2'b10);
    check("R4", "g1 done", d_done, 2'b10);
    check("R3", "g1 step1 lanes", d_en, {mb[31:16], 16'h0});
    check("R6", "ready with g0 idle", d_ready, 1);
    @(negedge clk);
    d_valid = 0;
    check("R6", "lowest idle picked", d_busy, 2'b01);
    check("R5", "g0 new warp", d_gwarp[5:0], 3);
    check("R3", "g0 new lanes", d_en, {16'h0, mc[15:0]});
    repeat (2) @(negedge clk);
    check("R1", "dual idle", d_busy, 0);

    // R7 / R8 double precision merge
    d_valid = 1; d_dp = 0; d_warp = 4; d_mask = ma; d_op = 8'h40;
    @(negedge clk);
    d_dp = 1; d_warp = 5; d_mask = md; d_op = 8'h44;
    #1 check("R7", "dp blocked by g0", d_ready, 0);
    @(negedge clk);
    check("R7", "dp blocked at g0 last step", d_ready, 0);
    check("R7", "g1 not taken by dp", d_busy, 2'b01);
    @(negedge clk);
    check("R7", "dp ready when both idle", d_ready, 1);
    @(negedge clk);
    d_valid = 0; d_dp = 0;
    check("R8", "merged busy", d_busy, 2'b11);
    check("R8", "merged flag", d_merged, 1);
    check("R8", "merged step0 lanes", d_en, {16'h0, md[15:0]});
    check("R8", "merged no done yet", d_done, 0);
    check("R2", "merged lane5 tid step0", d_tid[5*5 +: 5], 5);
    check("R5", "merged warp", d_gwarp[5:0], 5);
    @(negedge clk);
    check("R8", "merged step1 lanes", d_en, {16'h0, md[31:16]});
    check("R8", "merged done both", d_done, 2'b11);
    check("R2", "merged lane5 tid step1", d_tid[5*5 +: 5], 21);
    @(negedge clk);
    check("R8", "merge released", d_merged, 0);
    check("R8", "merge idle", d_busy, 0);

    // R3 zero mask in dual configuration
    d_valid = 1; d_mask = 0; d_warp = 9;
    @(negedge clk);
    d_valid = 0;
    check("R3", "zero mask busy", d_busy, 2'b01);
    check("R3", "zero mask no lanes", d_en, 0);
    @(negedge clk);
    check("R3", "zero mask done", d_done, 2'b01);
    check("R3", "zero mask still no lanes", d_en, 0);
    @(negedge clk);

    // R10 reset mid-instruction
    s_valid = 1; s_mask = '1;
    @(negedge clk);
    s_valid = 0;
    @(negedge clk);
    rst_n = 0;
    #1 check("R10", "reset clears busy", s_busy, 0);
    check("R10", "reset clears lanes", s_en, 0);
    check("R10", "reset restores ready", s_ready, 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    summary();
  end
endmodule